// File: doc/BRIEF.md
# Entropy Word Register Front-End

This block sits between a raw entropy source and a 32-bit register bus. Single entropy bits, each marked by a strobe, are shifted into 32-bit words. Complete words wait in a four-word FIFO until software reads them through a data register. A control register turns the block on, enables its interrupt and can mask clock-fault detection. A status register reports data availability, live and sticky clock-fault conditions, and live and sticky stuck-source conditions.

When the source repeats one value too long, the block treats it as a seed failure. It stops producing words and discards what it holds. Recovery has two steps. Software first writes zero to the sticky seed flag. It then issues a fixed number of data reads, which all return zero, before fresh words are accepted again.

The bus has one access per cycle. Read data is registered and appears in the cycle after the access.

Top module: `rng_regfront`

## Requirements
- R1: After reset, all register reads return 0 and `irq` is low.
- R2: Control register (offset 0x00) holds enable at bit 2, interrupt enable at bit 3 and clock-check disable at bit 5. All three read back as written, and its other bits read 0.
- R3: While enabled, each cycle with `ent_valid` high shifts in one sample of `ent_bit`. The sample taken i-th (counting from 0) lands at bit i of the word. A word goes to the FIFO after 32 samples. Samples taken while `ent_valid` is low or the block is disabled are ignored.
- R4: The FIFO holds four words. Status (offset 0x04) bit 0 is high when at least one readable word is waiting. Each read of the data register (offset 0x08) pops the oldest word, and a read with no word waiting returns 0. Samples that arrive while the FIFO is full are dropped.
- R5: 64 consecutive identical samples set status bit 2 (live seed fault) and status bit 6 (sticky seed flag). Bit 2 clears on the next differing sample, while bit 6 stays set.
- R6: While the sticky seed flag is set, the FIFO and the partial word are discarded, no samples are packed, and data reads return 0.
- R7: Writing 0 to status bit 6 clears the sticky seed flag unless the live seed fault is still present. Writing 1 to it leaves it unchanged.
- R8: After the sticky seed flag clears, the next 12 data reads return 0 and samples are still not packed. Packing resumes after the 12th such read.
- R9: With clock-check disable at 0, status bit 1 follows the `clk_fault` input one cycle later, and status bit 5 latches it until a 0 is written to bit 5. With clock-check disable at 1, neither bit sets.
- R10: Clearing enable empties the FIFO and discards the partial word.
- R11: `irq` is high, one cycle after its cause, when interrupt enable is set and status bit 0, bit 5 or bit 6 is high. Otherwise `irq` is low.
- R12: Reads of unmapped offsets return 0. Writes can only clear status bits 5 and 6 and never set any status bit. Writes to the data offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| ent_valid | input | 1 | Strobe qualifying `ent_bit` |
| ent_bit | input | 1 | Raw entropy sample |
| clk_fault | input | 1 | Clock-fault indication from outside |
| irq | output | 1 | Interrupt request |

## Verification
A packer whose bit count drifts shows up at the first data read: the word's bits are rotated relative to the samples fed in. A FIFO pointer or count error shows within four reads as a repeated word, a lost word or a zero where data was due. A flush counter loaded with the wrong value, or a sticky flag that fails to hold, makes the 12th or 13th post-recovery read, or the status read straight after a stuck run, return the wrong value.

// File: rtl/rng_regfront_pkg.sv
package rng_regfront_pkg;
  localparam int unsigned REG_W = 32;

  // register offsets
  localparam int unsigned OFS_CTRL = 'h0;
  localparam int unsigned OFS_STAT = 'h4;
  localparam int unsigned OFS_DATA = 'h8;

  // control fields
  localparam int unsigned CB_EN      = 2;
  localparam int unsigned CB_IE      = 3;
  localparam int unsigned CB_CLK_OFF = 5;

  // status fields
  localparam int unsigned SB_READY     = 0;
  localparam int unsigned SB_CLK_LIVE  = 1;
  localparam int unsigned SB_SEED_LIVE = 2;
  localparam int unsigned SB_CLK_FLAG  = 5;
  localparam int unsigned SB_SEED_FLAG = 6;
endpackage

// File: rtl/rng_bit_packer.sv
module rng_bit_packer #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              accept,
  input  logic              bit_in,
  output logic              push,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  fill;

  // newest sample enters at the top; after a full word the first one sits at bit 0
  assign word = {bit_in, shreg[WORD_W-1:1]};
  assign push = accept && (fill == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      shreg <= '0;
      fill  <= '0;
    end else if (accept) begin
      shreg <= word;
      fill  <= (fill == LAST) ? '0 : fill + 1'b1;
    end
  end
endmodule

// File: rtl/rng_word_fifo.sv
module rng_word_fifo #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       push,
  input  logic [WORD_W-1:0]          din,
  input  logic                       pop,
  output logic [WORD_W-1:0]          dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rng_seed_monitor.sv
module rng_seed_monitor #(
  parameter int unsigned RUN_LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic sample_valid,
  input  logic sample,
  output logic stuck
);
  localparam int unsigned RUN_W = $clog2(RUN_LIMIT + 1);
  localparam logic [RUN_W-1:0] LIMIT = RUN_W'(RUN_LIMIT);

  logic [RUN_W-1:0] run_len;
  logic             last;

  assign stuck = (run_len == LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_len <= '0;
      last    <= 1'b0;
    end else if (sample_valid) begin
      last <= sample;
      if (run_len != '0 && sample == last)
        run_len <= (run_len == LIMIT) ? run_len : run_len + 1'b1;
      else
        run_len <= RUN_W'(1);
    end
  end
endmodule

// File: rtl/rng_regfront.sv
module rng_regfront
  import rng_regfront_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned FIFO_DEPTH  = 4,
  parameter int unsigned RUN_LIMIT   = 64,
  parameter int unsigned FLUSH_WORDS = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             ent_valid,
  input  logic             ent_bit,
  input  logic             clk_fault,
  output logic             irq
);
  localparam int unsigned FL_W  = $clog2(FLUSH_WORDS + 1);
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

  logic en_q, ie_q, clk_off_q;
  logic clk_live_q, clk_flag_q, seed_flag_q, seed_flag_d;
  logic [FL_W-1:0] flush_q;
  logic [REG_W-1:0] rdata_q, rd_mux;
  logic irq_q;

  logic wr_acc, rd_acc, hit_ctrl, hit_stat, hit_data, dr_read;
  logic halt, accept, r_ready;
  logic secs;
  logic pk_push;
  logic [REG_W-1:0] pk_word, fifo_dout;
  logic fifo_empty, fifo_full, fifo_clr;
  logic [CNT_W-1:0] fifo_count;

  assign wr_acc   = bus_valid && bus_write;
  assign rd_acc   = bus_valid && !bus_write;
  assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign hit_data = (bus_addr == ADDR_W'(OFS_DATA));
  assign dr_read  = rd_acc && hit_data;

  assign halt     = seed_flag_q || (flush_q != '0);
  assign r_ready  = !fifo_empty && !halt;
  assign accept   = ent_valid && en_q && !halt && !fifo_full;
  assign fifo_clr = !en_q || seed_flag_q;

  rng_seed_monitor #(.RUN_LIMIT(RUN_LIMIT)) i_mon (
    .clk(clk), .rst(rst), .clr(!en_q),
    .sample_valid(ent_valid), .sample(ent_bit), .stuck(secs)
  );

  rng_bit_packer #(.WORD_W(REG_W)) i_pack (
    .clk(clk), .rst(rst), .clr(fifo_clr),
    .accept(accept), .bit_in(ent_bit),
    .push(pk_push), .word(pk_word)
  );

  rng_word_fifo #(.WORD_W(REG_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk(clk), .rst(rst), .clr(fifo_clr),
    .push(pk_push), .din(pk_word),
    .pop(dr_read && r_ready),
    .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full),
    .count(fifo_count)
  );

  // a live fault takes priority over a software clear
  always_comb begin
    seed_flag_d = seed_flag_q;
    if (secs)
      seed_flag_d = 1'b1;
    else if (wr_acc && hit_stat && !bus_wdata[SB_SEED_FLAG])
      seed_flag_d = 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) begin
      rd_mux[CB_EN]      = en_q;
      rd_mux[CB_IE]      = ie_q;
      rd_mux[CB_CLK_OFF] = clk_off_q;
    end else if (hit_stat) begin
      rd_mux[SB_READY]     = r_ready;
      rd_mux[SB_CLK_LIVE]  = clk_live_q;
      rd_mux[SB_SEED_LIVE] = secs;
      rd_mux[SB_CLK_FLAG]  = clk_flag_q;
      rd_mux[SB_SEED_FLAG] = seed_flag_q;
    end else if (hit_data) begin
      rd_mux = r_ready ? fifo_dout : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q        <= 1'b0;
      ie_q        <= 1'b0;
      clk_off_q   <= 1'b0;
      clk_live_q  <= 1'b0;
      clk_flag_q  <= 1'b0;
      seed_flag_q <= 1'b0;
      flush_q     <= '0;
      rdata_q     <= '0;
      irq_q       <= 1'b0;
    end else begin
      if (wr_acc && hit_ctrl) begin
        en_q      <= bus_wdata[CB_EN];
        ie_q      <= bus_wdata[CB_IE];
        clk_off_q <= bus_wdata[CB_CLK_OFF];
      end

      clk_live_q <= clk_fault && !clk_off_q;
      if (clk_live_q)
        clk_flag_q <= 1'b1;
      else if (wr_acc && hit_stat && !bus_wdata[SB_CLK_FLAG])
        clk_flag_q <= 1'b0;

      seed_flag_q <= seed_flag_d;
      if (seed_flag_q && !seed_flag_d)
        flush_q <= FL_W'(FLUSH_WORDS);
      else if (dr_read && flush_q != '0)
        flush_q <= flush_q - 1'b1;

      if (rd_acc) rdata_q <= rd_mux;
      irq_q <= ie_q && (r_ready || clk_flag_q || seed_flag_q);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/rng_regfront_chk.sv
module rng_regfront_chk #(
  parameter int unsigned FIFO_DEPTH  = 4,
  parameter int unsigned FLUSH_WORDS = 12,
  parameter int unsigned CNT_W       = 3,
  parameter int unsigned FL_W        = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             ie,
  input logic             clk_off,
  input logic             clk_live,
  input logic             seed_flag,
  input logic             secs,
  input logic             push,
  input logic [CNT_W-1:0] fifo_count,
  input logic [FL_W-1:0]  flush,
  input logic             dr_read,
  input logic             irq
);
  p_fifo_bound_r4: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CNT_W'(FIFO_DEPTH));

  p_seed_latch_r5: assert property (@(posedge clk) disable iff (rst)
    secs |=> seed_flag);

  p_halt_no_push_r6: assert property (@(posedge clk) disable iff (rst)
    (seed_flag || flush != '0) |-> !push);

  p_flush_load_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(seed_flag) |-> (flush == FL_W'(FLUSH_WORDS)));

  p_flush_step_r8: assert property (@(posedge clk) disable iff (rst)
    (flush != '0 && dr_read) |=> (flush == $past(flush) - 1'b1));

  p_ced_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    clk_off |=> !clk_live);

  p_off_empty_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (fifo_count == '0));

  p_irq_mask_r11: assert property (@(posedge clk) disable iff (rst)
    !ie |=> !irq);
endmodule

bind rng_regfront rng_regfront_chk #(
  .FIFO_DEPTH(FIFO_DEPTH), .FLUSH_WORDS(FLUSH_WORDS),
  .CNT_W(CNT_W), .FL_W(FL_W)
) i_chk (
  .clk(clk), .rst(rst), .en(en_q), .ie(ie_q), .clk_off(clk_off_q),
  .clk_live(clk_live_q), .seed_flag(seed_flag_q), .secs(secs),
  .push(pk_push), .fifo_count(fifo_count), .flush(flush_q),
  .dr_read(dr_read), .irq(irq)
);

// File: tb/test_rng_regfront.sv
module test_rng_regfront;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ent_valid = 1'b0, ent_bit = 1'b0, clk_fault = 1'b0;
  logic        irq;
  int          errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rng_regfront i_rng_regfront (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ent_valid(ent_valid), .ent_bit(ent_bit), .clk_fault(clk_fault), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk); d = bus_rdata; bus_valid = 0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic feed_bit(input logic b);
    @(negedge clk); ent_valid = 1; ent_bit = b;
    @(negedge clk); ent_valid = 0;
  endtask

  task automatic feed_word(input logic [31:0] w);
    for (int i = 0; i < 32; i++) feed_bit(w[i]);
  endtask

  task automatic feed_run(input logic b, input int n);
    for (int i = 0; i < n; i++) feed_bit(b);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk(4'h0, 32'h0, "R1 ctrl after reset");
    rd_chk(4'h4, 32'h0, "R1 status after reset");
    rd_chk(4'h8, 32'h0, "R1 data after reset");
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ctrl;
    wr(4'h0, 32'hFFFF_FFFF);
    rd_chk(4'h0, 32'h0000_002C, "R2 ctrl readback");
    wr(4'h0, 32'h0);
    rd_chk(4'h0, 32'h0, "R2 ctrl cleared");
  endtask

  task automatic t_pack;
    wr(4'h0, 32'h4);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); ent_bit = i[0];   // no strobe: must be ignored (R3)
    end
    feed_word(32'hA5C3_1E97);
    rd_chk(4'h4, 32'h1, "R4 ready with one word");
    rd_chk(4'h8, 32'hA5C3_1E97, "R3 word bit order");
    rd_chk(4'h4, 32'h0, "R4 ready drops after pop");
  endtask

  task automatic t_fifo_full;
    logic [31:0] w [5];
    w[0] = 32'h1357_9BDF; w[1] = 32'h2468_ACE0; w[2] = 32'h0F1E_2D3C;
    w[3] = 32'h7766_5544; w[4] = 32'hDEAD_BEEF;
    for (int i = 0; i < 5; i++) feed_word(w[i]);
    for (int i = 0; i < 4; i++) rd_chk(4'h8, w[i], "R4 FIFO order");
    rd_chk(4'h8, 32'h0, "R4 word while full dropped, empty read 0");
  endtask

  task automatic t_irq;
    wr(4'h0, 32'hC);
    idle(2);
    chk("R11 irq low with nothing pending", {31'b0, irq}, 32'h0);
    feed_word(32'h3C5A_96E1);
    idle(2);
    chk("R11 irq on ready", {31'b0, irq}, 32'h1);
    rd_chk(4'h8, 32'h3C5A_96E1, "R3 word under irq");
    idle(2);
    chk("R11 irq drops", {31'b0, irq}, 32'h0);
    wr(4'h0, 32'h4);
    feed_word(32'h6B2D_4C19);
    idle(2);
    chk("R11 irq masked", {31'b0, irq}, 32'h0);
    rd_chk(4'h8, 32'h6B2D_4C19, "R4 masked word read");
  endtask

  task automatic t_disable;
    feed_word(32'h1122_3348);
    feed_run(1'b1, 3); feed_run(1'b0, 5); feed_run(1'b1, 8);
    wr(4'h0, 32'h0);
    rd_chk(4'h4, 32'h0, "R10 disable empties FIFO");
    feed_word(32'h5A5A_1234);
    wr(4'h0, 32'h4);
    rd_chk(4'h4, 32'h0, "R3 samples while disabled ignored");
    feed_word(32'hC0DE_7E57);
    rd_chk(4'h8, 32'hC0DE_7E57, "R10 partial word discarded");
    rd_chk(4'h8, 32'h0, "R10 nothing else queued");
  endtask

  task automatic t_seed;
    feed_word(32'h1234_5678);
    feed_run(1'b1, 64);
    rd_chk(4'h4, 32'h44, "R5 live and sticky seed set");
    rd_chk(4'h8, 32'h0, "R6 data dropped on seed fault");
    feed_bit(1'b0);
    rd_chk(4'h4, 32'h40, "R5 live clears, sticky holds");
    feed_word(32'h0F0F_3355);
    rd_chk(4'h4, 32'h40, "R6 no packing while flagged");
    wr(4'h4, 32'h40);
    rd_chk(4'h4, 32'h40, "R7 write 1 keeps flag");
    wr(4'h4, 32'h0);
    rd_chk(4'h4, 32'h0, "R7 write 0 clears flag");
    feed_word(32'h5555_5555);
    for (int i = 0; i < 11; i++) rd_chk(4'h8, 32'h0, "R8 flush read returns 0");
    feed_word(32'h2222_4444);
    rd_chk(4'h4, 32'h0, "R8 no packing before 12th read");
    rd_chk(4'h8, 32'h0, "R8 12th flush read");
    feed_word(32'h9ABC_DEF0);
    rd_chk(4'h8, 32'h9ABC_DEF0, "R8 generation resumes");
  endtask

  task automatic t_seed_persist;
    wr(4'h0, 32'hC);
    feed_run(1'b0, 64);
    idle(2);
    chk("R11 irq on seed flag", {31'b0, irq}, 32'h1);
    wr(4'h4, 32'h0);
    rd_chk(4'h4, 32'h44, "R7 clear refused while live");
    feed_bit(1'b1);
    wr(4'h4, 32'h0);
    rd_chk(4'h4, 32'h0, "R7 clear after live drops");
    for (int i = 0; i < 12; i++) rd_chk(4'h8, 32'h0, "R8 second flush");
    wr(4'h0, 32'h0);
  endtask

  task automatic t_clk_err;
    wr(4'h0, 32'h8);
    @(negedge clk); clk_fault = 1;
    idle(2);
    rd_chk(4'h4, 32'h22, "R9 live and sticky clock fault");
    chk("R11 irq on clock flag", {31'b0, irq}, 32'h1);
    @(negedge clk); clk_fault = 0;
    idle(2);
    rd_chk(4'h4, 32'h20, "R9 sticky clock flag holds");
    wr(4'h4, 32'h0);
    rd_chk(4'h4, 32'h0, "R9 clock flag cleared by 0");
    idle(2);
    chk("R11 irq released", {31'b0, irq}, 32'h0);
    wr(4'h0, 32'h28);
    @(negedge clk); clk_fault = 1;
    idle(3);
    rd_chk(4'h4, 32'h0, "R9 check disabled");
    @(negedge clk); clk_fault = 0;
    wr(4'h0, 32'h0);
  endtask

  task automatic t_addr;
    rd_chk(4'hC, 32'h0, "R12 unmapped read");
    wr(4'h4, 32'hFFFF_FFFF);
    rd_chk(4'h4, 32'h0, "R12 status not settable");
    wr(4'h0, 32'h4);
    wr(4'h8, 32'hFFFF_FFFF);
    rd_chk(4'h0, 32'h4, "R12 data write ignored");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_ctrl();
    t_pack();
    t_fifo_full();
    t_irq();
    t_disable();
    t_seed();
    t_seed_persist();
    t_clk_err();
    t_addr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule